// File: doc/BRIEF.md
# Upstream High-Speed Detection Handshake Controller

This block sits behind the upstream-facing port of a USB 2.0 hub. It watches the decoded upstream line state and decides when a stretch of SE0 from the host is a bus reset. The hub's own state decides how long it waits. A suspended hub reacts after a short filtered run of SE0. A full-speed hub waits a longer, fixed window. A hub running at high speed first waits out the window that tells reset from suspend, then drops back to full speed. After a settle time it samples the bus: SE0 means reset and J means suspend.

Once a reset is recognised, the block emits a one-cycle reset event and asks the transceiver to drive its own Chirp K for a fixed time. It then listens for the host's alternating chirps. Each host K or J counts only after it has been stable for a filter time. When enough K-J pairs have been seen, starting with a K, high-speed operation is enabled. If they do not arrive within a timeout, the block stays in the full-speed default. All windows are counted in cycles of the reference clock: 24 MHz with the default parameters.

Top module: `us_hs_handshake`

## Requirements
- R1: While `rst_n` is low, `chirp_k`, `hs_en`, `reset_evt` and `susp_evt` are 0, whatever the line does. Asserting `rst_n` clears them at once, even in the middle of a chirp.
- R2: With `suspended` high, the block recognises a reset on the edge that takes the SUSP_WAIT_CYC-th consecutive SE0 sample (`line_st` = 2'b00). This holds whatever the value of `hs_mode`.
- R3: With `suspended` low and `hs_mode` low, the block recognises a reset on the edge that takes the FS_WAIT_CYC-th consecutive SE0 sample.
- R4: With `suspended` low and `hs_mode` high, `hs_en` clears on the edge that takes the HS_WAIT_CYC-th consecutive SE0 sample. SETTLE_CYC cycles later the line is sampled, and SE0 there is recognised as a reset.
- R5: In the R4 case, if the settle-time sample is J (`line_st` = 2'b01), `susp_evt` pulses for one cycle. No reset event and no chirp follow.
- R6: A run of SE0 shorter than the active window produces no event and no chirp.
- R7: `chirp_k` is high for exactly CHIRP_CYC cycles. It rises in the same cycle as `reset_evt`, and `hs_en` is 0 throughout.
- R8: After the chirp, a host K (`line_st` = 2'b10) or J counts only once FILT_CYC consecutive samples of that symbol have been taken. Shorter runs are ignored.
- R9: `hs_en` rises in the cycle after the FILT_CYC-th sample of the J that completes PAIRS K-J pairs in order. A J seen before the first K does not count.
- R10: If no complete sequence arrives within LISTEN_CYC cycles of the end of the chirp, the block returns to idle with `hs_en` at 0.
- R11: `reset_evt` is a single-cycle pulse, once per recognised reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Decoded upstream line: 00 SE0, 01 J, 10 K, 11 SE1 |
| hs_mode | input | 1 | Hub currently operating at high speed |
| suspended | input | 1 | Hub currently suspended |
| chirp_k | output | 1 | Request to drive Chirp K upstream |
| hs_en | output | 1 | High-speed operation enabled |
| reset_evt | output | 1 | One-cycle pulse: upstream bus reset recognised |
| susp_evt | output | 1 | One-cycle pulse: suspend recognised from high speed |

## Verification
Take the edge that samples the first SE0 as index 0. `reset_evt` and the rise of `chirp_k` are then due at index W-1 for the suspended and full-speed windows. In the high-speed branch they are due at HS_WAIT_CYC+SETTLE_CYC-1, and `susp_evt` at the same index. `hs_en` rises at the index of the FILT_CYC-th sample of the last host J, because every output comes straight from a register updated on that edge. The bench drives each input step just after a falling edge and reads the outputs at the next falling edge. The result of edge k is therefore always recorded as index k. Every vector compares exact first-occurrence indices and pulse counts, so an output that comes one cycle early or late is reported.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REVERT,
    ST_CHIRP,
    ST_LISTEN
  } hs_st_t;

  typedef enum logic [1:0] {
    BR_SUSP,
    BR_FS,
    BR_HS
  } branch_t;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsd_rst_sync.sv
module hsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/hsd_timer.sv
module hsd_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] lim,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == lim);

  // The window counter never runs past the limit of the state it serves.
  AST_TMR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= lim)); // R7
endmodule

// File: rtl/hsd_chirp_filter.sv
module hsd_chirp_filter
  import hsd_pkg::*;
#(
  parameter int unsigned FILT_CYC = 60,
  parameter int unsigned PAIRS    = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  line_t line,
  output logic  hit
);
  localparam int unsigned RW     = $clog2(FILT_CYC + 1);
  localparam int unsigned HALVES = 2 * PAIRS;
  localparam int unsigned HW     = $clog2(HALVES + 1);

  line_t         lsym_q, lsym_d;
  logic [RW-1:0] run_q, run_d;
  logic [HW-1:0] half_q, half_d;
  logic          is_chirp, same, qual, good;
  line_t         expect_sym;

  always_comb begin
    is_chirp   = (line == LS_J) || (line == LS_K);
    same       = is_chirp && (line == lsym_q);
    qual       = en && same && (run_q == RW'(FILT_CYC - 1));
    expect_sym = half_q[0] ? LS_J : LS_K;
    good       = qual && (line == expect_sym);
    hit        = good && (half_q == HW'(HALVES - 1));
  end

  always_comb begin
    lsym_d = lsym_q;
    run_d  = run_q;
    half_d = half_q;
    if (!en) begin
      lsym_d = LS_SE0;
      run_d  = '0;
      half_d = '0;
    end else begin
      if (!is_chirp) begin
        lsym_d = LS_SE0;
        run_d  = '0;
      end else if (same) begin
        if (run_q != RW'(FILT_CYC)) run_d = run_q + RW'(1);
      end else begin
        lsym_d = line;
        run_d  = RW'(1);
      end
      if (qual) begin
        if (good)              half_d = half_q + HW'(1);
        else if (line == LS_K) half_d = HW'(1);
        else                   half_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsym_q <= LS_SE0;
      run_q  <= '0;
      half_q <= '0;
    end else begin
      lsym_q <= lsym_d;
      run_q  <= run_d;
      half_q <= half_d;
    end
  end

  // A completed sequence ends the listening phase on the next edge.
  AST_HIT_ENDS_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !en); // R9
  // The pair count stays inside the sequence length.
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (half_q < HW'(HALVES))); // R8
endmodule

// File: rtl/us_hs_handshake.sv
module us_hs_handshake
  import hsd_pkg::*;
#(
  parameter int unsigned SUSP_WAIT_CYC = 60,
  parameter int unsigned FS_WAIT_CYC   = 2400,
  parameter int unsigned HS_WAIT_CYC   = 72000,
  parameter int unsigned SETTLE_CYC    = 4800,
  parameter int unsigned CHIRP_CYC     = 36000,
  parameter int unsigned LISTEN_CYC    = 48000,
  parameter int unsigned FILT_CYC      = 60,
  parameter int unsigned PAIRS         = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  input  logic       hs_mode,
  input  logic       suspended,
  output logic       chirp_k,
  output logic       hs_en,
  output logic       reset_evt,
  output logic       susp_evt
);
  localparam int unsigned MAX_LIM = umax(umax(umax(SUSP_WAIT_CYC, FS_WAIT_CYC),
                                              umax(HS_WAIT_CYC, SETTLE_CYC)),
                                         umax(CHIRP_CYC, LISTEN_CYC));
  localparam int unsigned CW = $clog2(MAX_LIM + 1);

  logic          srst_n;
  line_t         ln;
  hs_st_t        st_q, st_d;
  branch_t       br_q, br_d;
  logic          hs_q, hs_d;
  logic          rst_evt_q, rst_evt_d;
  logic          susp_evt_q, susp_evt_d;
  logic [CW-1:0] lim;
  logic          tmr_done, tmr_clr, tmr_en;
  logic          seq_hit, listen_en;

  assign ln = line_t'(line_st);

  hsd_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  hsd_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .lim   (lim),
    .done  (tmr_done)
  );

  hsd_chirp_filter #(.FILT_CYC(FILT_CYC), .PAIRS(PAIRS)) u_filter (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (listen_en),
    .line  (ln),
    .hit   (seq_hit)
  );

  assign listen_en = (st_q == ST_LISTEN);
  assign tmr_en    = (st_q != ST_IDLE);
  assign tmr_clr   = (st_d != st_q);

  // Window limit per state; the SE0 run counts its first sample in idle.
  always_comb begin
    lim = '0;
    unique case (st_q)
      ST_WAIT: begin
        unique case (br_q)
          BR_SUSP: lim = CW'(SUSP_WAIT_CYC - 2);
          BR_HS:   lim = CW'(HS_WAIT_CYC - 2);
          default: lim = CW'(FS_WAIT_CYC - 2);
        endcase
      end
      ST_REVERT: lim = CW'(SETTLE_CYC - 1);
      ST_CHIRP:  lim = CW'(CHIRP_CYC - 1);
      ST_LISTEN: lim = CW'(LISTEN_CYC - 1);
      default:   lim = '0;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    br_d       = br_q;
    hs_d       = hs_q;
    rst_evt_d  = 1'b0;
    susp_evt_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ln == LS_SE0) begin
          st_d = ST_WAIT;
          if (suspended)    br_d = BR_SUSP;
          else if (hs_mode) br_d = BR_HS;
          else              br_d = BR_FS;
        end
      end
      ST_WAIT: begin
        if (ln != LS_SE0) begin
          st_d = ST_IDLE;
        end else if (tmr_done) begin
          hs_d = 1'b0;
          if (br_q == BR_HS) begin
            st_d = ST_REVERT;
          end else begin
            st_d      = ST_CHIRP;
            rst_evt_d = 1'b1;
          end
        end
      end
      ST_REVERT: begin
        if (tmr_done) begin
          if (ln == LS_SE0) begin
            st_d      = ST_CHIRP;
            rst_evt_d = 1'b1;
          end else begin
            st_d       = ST_IDLE;
            susp_evt_d = (ln == LS_J);
          end
        end
      end
      ST_CHIRP: begin
        if (tmr_done) st_d = ST_LISTEN;
      end
      ST_LISTEN: begin
        if (seq_hit) begin
          st_d = ST_IDLE;
          hs_d = 1'b1;
        end else if (tmr_done) begin
          st_d = ST_IDLE;
          hs_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q       <= ST_IDLE;
      br_q       <= BR_FS;
      hs_q       <= 1'b0;
      rst_evt_q  <= 1'b0;
      susp_evt_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      br_q       <= br_d;
      hs_q       <= hs_d;
      rst_evt_q  <= rst_evt_d;
      susp_evt_q <= susp_evt_d;
    end
  end

  assign chirp_k   = (st_q == ST_CHIRP);
  assign hs_en     = hs_q;
  assign reset_evt = rst_evt_q;
  assign susp_evt  = susp_evt_q;

  AST_RST_EVT_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    reset_evt |=> !reset_evt); // R11
  AST_CHIRP_WITH_EVT: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(chirp_k) |-> reset_evt); // R7
  AST_NO_HS_IN_CHIRP: assert property (@(posedge clk) disable iff (!srst_n)
    chirp_k |-> !hs_en); // R7
  AST_SUSP_NO_CHIRP: assert property (@(posedge clk) disable iff (!srst_n)
    susp_evt |-> (!reset_evt && !chirp_k)); // R5
  AST_HS_FROM_LISTEN: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(hs_en) |-> ($past(st_q) == ST_LISTEN)); // R9
  AST_REVERT_FS: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_REVERT) |-> !hs_en); // R4
endmodule

// File: tb/sim_us_hs_handshake.sv
module sim_us_hs_handshake;

  localparam int TOTAL = 110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_st = 2'b01;
  logic       hs_mode = 1'b0;
  logic       suspended = 1'b0;
  logic       chirp_k, hs_en, reset_evt, susp_evt;

  int n_checks = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  us_hs_handshake #(
    .SUSP_WAIT_CYC(5), .FS_WAIT_CYC(10), .HS_WAIT_CYC(20), .SETTLE_CYC(6),
    .CHIRP_CYC(12), .LISTEN_CYC(40), .FILT_CYC(4), .PAIRS(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .hs_mode(hs_mode),
    .suspended(suspended), .chirp_k(chirp_k), .hs_en(hs_en),
    .reset_evt(reset_evt), .susp_evt(susp_evt)
  );

  typedef struct packed {
    logic       susp;
    logic       hsm;
    logic       startj;
    logic [7:0] s;
    logic [7:0] hl;
    logic [7:0] halves;
    logic [7:0] e_rst;
    logic [7:0] e_trst;
    logic [7:0] e_susp;
    logic [7:0] e_tsusp;
    logic [7:0] e_chirp;
    logic       e_hs;
    logic [7:0] e_ths;
  } vec_t;

  // susp hsm startj | se0 len, half len, halves | rst, t_rst, susp, t_susp, chirp, hs, t_hs
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 1'b0, 8'd20, 8'd5, 8'd6, 8'd1, 8'd4,   8'd0, 8'd255, 8'd12, 1'b1, 8'd48},
    '{1'b0, 1'b0, 1'b0, 8'd24, 8'd4, 8'd6, 8'd1, 8'd9,   8'd0, 8'd255, 8'd12, 1'b1, 8'd47},
    '{1'b0, 1'b0, 1'b0, 8'd24, 8'd4, 8'd4, 8'd1, 8'd9,   8'd0, 8'd255, 8'd12, 1'b0, 8'd255},
    '{1'b0, 1'b0, 1'b0, 8'd9,  8'd4, 8'd0, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0,  1'b0, 8'd255},
    '{1'b0, 1'b1, 1'b0, 8'd40, 8'd6, 8'd6, 8'd1, 8'd25,  8'd0, 8'd255, 8'd12, 1'b1, 8'd73},
    '{1'b0, 1'b1, 1'b0, 8'd23, 8'd4, 8'd0, 8'd0, 8'd255, 8'd1, 8'd25,  8'd0,  1'b0, 8'd255},
    '{1'b0, 1'b0, 1'b1, 8'd24, 8'd4, 8'd7, 8'd1, 8'd9,   8'd0, 8'd255, 8'd12, 1'b1, 8'd51},
    '{1'b0, 1'b0, 1'b0, 8'd24, 8'd3, 8'd6, 8'd1, 8'd9,   8'd0, 8'd255, 8'd12, 1'b0, 8'd255},
    '{1'b1, 1'b1, 1'b0, 8'd20, 8'd5, 8'd6, 8'd1, 8'd4,   8'd0, 8'd255, 8'd12, 1'b1, 8'd48}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string rst_tag(input vec_t v);
    if (v.e_rst == 8'd0 && !v.hsm) return "R6";
    if (v.susp) return "R2";
    if (v.hsm)  return "R4";
    return "R3";
  endfunction

  task automatic idle_j(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_st = 2'b01;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n_rst, t_rst, n_susp, t_susp, n_chirp, t_hs;
    logic prev_hs;
    n_rst = 0; t_rst = 255; n_susp = 0; t_susp = 255; n_chirp = 0; t_hs = 255;
    idle_j(3);
    suspended = v.susp;
    hs_mode   = v.hsm;
    prev_hs   = hs_en;
    for (int i = 0; i <= TOTAL; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (reset_evt) begin n_rst++;  if (t_rst == 255)  t_rst = i - 1;  end
        if (susp_evt)  begin n_susp++; if (t_susp == 255) t_susp = i - 1; end
        if (chirp_k) n_chirp++;
        if (hs_en && !prev_hs && t_hs == 255) t_hs = i - 1;
        prev_hs = hs_en;
      end
      if (i < TOTAL) begin
        if (i < int'(v.s)) begin
          line_st = 2'b00;
        end else begin
          int h;
          h = (v.hl > 0) ? (i - int'(v.s)) / int'(v.hl) : 0;
          if (v.hl > 0 && h < int'(v.halves))
            line_st = (((h + int'(v.startj)) % 2) == 0) ? 2'b10 : 2'b01;
          else
            line_st = 2'b01;
        end
      end
    end
    chk("R11", "reset pulse count", n_rst, int'(v.e_rst));
    chk(rst_tag(v), "reset index", t_rst, int'(v.e_trst));
    chk("R5", "suspend pulse count", n_susp, int'(v.e_susp));
    chk("R5", "suspend index", t_susp, int'(v.e_tsusp));
    chk("R7", "chirp cycles", n_chirp, int'(v.e_chirp));
    chk(v.e_hs ? "R9" : "R10", "hs_en final", int'(hs_en), int'(v.e_hs));
    chk("R8", "hs_en rise index", t_hs, int'(v.e_ths));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything low even with SE0 on the line
    line_st = 2'b00;
    repeat (8) @(negedge clk);
    chk("R1", "chirp_k in reset", int'(chirp_k), 0);
    chk("R1", "hs_en in reset", int'(hs_en), 0);
    chk("R1", "reset_evt in reset", int'(reset_evt), 0);
    chk("R1", "susp_evt in reset", int'(susp_evt), 0);
    line_st = 2'b01;
    rst_n = 1'b1;
    idle_j(5);

    for (int k = 0; k < 9; k++) run_vec(VECS[k]);

    // R1: asynchronous reset during the hub chirp
    idle_j(3);
    suspended = 1'b0;
    hs_mode   = 1'b0;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      line_st = 2'b00;
    end
    @(negedge clk);
    chk("R7", "chirp_k mid-chirp", int'(chirp_k), 1);
    line_st = 2'b01;
    rst_n = 1'b0;
    #1;
    chk("R1", "chirp_k after async reset", int'(chirp_k), 0);
    chk("R1", "hs_en after async reset", int'(hs_en), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_j(4);
    chk("R1", "chirp_k after release", int'(chirp_k), 0);
    chk("R1", "reset_evt after release", int'(reset_evt), 0);

    // R3: a fresh full-speed handshake after reset
    run_vec(VECS[1]);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule